// File: doc/BRIEF.md
# Shared-Bus Ownership Arbiter

This block decides which of four masters may drive a shared bus and walks each master through a three-signal ownership handshake. All three handshake signals are active low: a request line from each master, a grant line from the central arbiter to each master, and a single busy line shared by all of them. A master that wants the bus raises its request. It then waits until it holds the grant and the busy line is released. At that point it claims the bus by driving busy and withdrawing its request. It keeps busy for the whole transfer and frees it when the transfer ends.

The host side of each master has two controls. A level input says that the master wants the bus. A one-cycle pulse says that the master's transfer has finished. The data transfer itself is outside this block. The arbiter offers the bus to one requester at a time in circular order. The search starts just after the master that last took ownership. The arbiter withdraws its offer as soon as it sees busy claimed. It also withdraws the offer if the chosen master gives up its request first. It makes no new offer while busy is held.

Top module: `bus_arb_top`

## Requirements
- R1: While reset is asserted, every request, grant and busy line is high (inactive) and no master reports ownership.
- R2: A master that is idle and whose want input is high drives its request line low one clock later.
- R3: At most one grant line is low at any time. The arbiter drives a grant low one clock after it sees a pending request while busy is high.
- R4: A master that holds a low grant and sees busy high, with want still high, takes ownership one clock later. In that same clock it drives busy low and returns its request line high.
- R5: The arbiter returns every grant line high one clock after it sees busy low. It drives no grant low while busy is low.
- R6: An owning master releases busy (busy high, ownership cleared) one clock after its done pulse. A done pulse to a master that does not own the bus has no effect on any output.
- R7: The grant goes to the first requesting master after the last owner in the order 0, 1, 2, 3, 0. After reset, master 0 has the highest priority.
- R8: A master whose want input falls before it claims the bus returns its request high one clock later. The arbiter then returns its grant high one clock after that, and the master never takes ownership.
- R9: At most one master reports ownership at a time. Busy is low exactly while some master owns the bus.
- R10: An owner keeps the bus until its done pulse, whatever its want input does. If want is still high after release, the master requests again one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| want_i | input | NREQ | Per-master level: the host wants the bus |
| done_i | input | NREQ | Per-master one-cycle pulse: transfer finished |
| br_n_o | output | NREQ | Per-master bus request, active low |
| bg_n_o | output | NREQ | Per-master bus grant from the arbiter, active low |
| bb_n_o | output | 1 | Shared bus busy, active low |
| own_o | output | NREQ | One-hot flag of the master that currently owns the bus |

## Verification
Some properties are checked on every cycle of every run: there is never more than one grant or one owner, the grant is dropped right after busy is claimed, no grant appears while busy is held, a claim always follows a grant and withdraws the request, and an owner releases exactly on its done pulse. Other behaviour shows up only in the bench's scenarios. These are the circular order of winners across many handovers, the exact cycle latency of each handshake step, the loss of a grant when a master gives up early, and the fact that stray done pulses have no effect. The bench checks them against a cycle model written from the requirements.

// File: rtl/bus_arb_pkg.sv
// Shared types for the bus ownership arbiter.
// Assumes: encodings are internal only and are not seen at any port.
package bus_arb_pkg;

    // Handshake state of one master.
    typedef enum logic [1:0] {
        MST_IDLE = 2'd0,   // not asking for the bus
        MST_WAIT = 2'd1,   // request driven, waiting for grant and free bus
        MST_OWN  = 2'd2    // busy driven, transfer in progress
    } mst_state_e;

    // State of the central arbiter.
    typedef enum logic {
        ARB_FREE  = 1'b0,  // no grant outstanding
        ARB_OFFER = 1'b1   // one grant driven, waiting for claim or withdrawal
    } arb_state_e;

endpackage

// File: rtl/bus_req_ctl.sv
// Per-master handshake controller.
// Raises the request while the host wants the bus. Claims the bus once it is
// granted and the shared busy line is high, and holds busy until done.
// Assumes: done_i is a single-cycle pulse. Grant and busy come from the same clock domain.
module bus_req_ctl
    import bus_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic done_i,
    input  logic bg_n_i,
    input  logic bb_n_i,
    output logic br_n_o,
    output logic busy_drv_o,
    output logic own_o
);

    mst_state_e state_q;

    // Advance the request/claim/release sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MST_IDLE;
        end else begin
            unique case (state_q)
                MST_IDLE: if (want_i) state_q <= MST_WAIT;
                MST_WAIT: begin
                    if (!want_i)                 state_q <= MST_IDLE;
                    else if (!bg_n_i && bb_n_i)  state_q <= MST_OWN;
                end
                MST_OWN:  if (done_i) state_q <= MST_IDLE;
                default:  state_q <= MST_IDLE;
            endcase
        end
    end

    // Decode the handshake lines from the state.
    always_comb begin
        br_n_o     = (state_q != MST_WAIT);
        busy_drv_o = (state_q == MST_OWN);
        own_o      = (state_q == MST_OWN);
    end

endmodule

// File: rtl/bus_rr_pick.sv
// Circular-priority selector.
// Finds the first set request bit after position last_i, wrapping around.
// last_i itself is checked last.
// Assumes: last_i < NREQ. Purely combinational.
module bus_rr_pick #(
    parameter int NREQ = 4,
    localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0] req_i,
    input  logic [IW-1:0]   last_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);

    // Walk the candidates in circular order and keep the first hit.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int off = 1; off <= NREQ; off++) begin
            int cand;
            cand = (int'(last_i) + off) % NREQ;
            if (!found_o && req_i[cand]) begin
                found_o = 1'b1;
                idx_o   = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/bus_grant_arb.sv
// Central arbiter.
// Offers the bus to one requester at a time, only while busy is high.
// Withdraws the offer when busy is claimed or when the chosen requester gives up.
// Remembers the last owner so that the next search starts after it.
// Assumes: requests and busy are active low and synchronous to clk.
module bus_grant_arb
    import bus_arb_pkg::*;
#(
    parameter int NREQ = 4,
    localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] br_n_i,
    input  logic            bb_n_i,
    output logic [NREQ-1:0] bg_n_o
);

    arb_state_e      state_q;
    logic [IW-1:0]   gnt_q;
    logic [IW-1:0]   last_q;
    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    logic [NREQ-1:0] req_act;

    // Turn the active-low requests into an active-high vector for the selector.
    always_comb req_act = ~br_n_i;

    bus_rr_pick #(.NREQ(NREQ)) u_pick (
        .req_i   (req_act),
        .last_i  (last_q),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    // Offer, withdraw and remember the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            gnt_q   <= '0;
            last_q  <= IW'(NREQ - 1);
        end else begin
            unique case (state_q)
                ARB_FREE: begin
                    if (bb_n_i && pick_found) begin
                        state_q <= ARB_OFFER;
                        gnt_q   <= pick_idx;
                    end
                end
                ARB_OFFER: begin
                    if (!bb_n_i) begin
                        state_q <= ARB_FREE;
                        last_q  <= gnt_q;
                    end else if (br_n_i[gnt_q]) begin
                        state_q <= ARB_FREE;
                    end
                end
                default: state_q <= ARB_FREE;
            endcase
        end
    end

    // Drive one active-low grant line per requester.
    for (genvar gi = 0; gi < NREQ; gi++) begin : g_grant
        assign bg_n_o[gi] = !((state_q == ARB_OFFER) && (gnt_q == IW'(gi)));
    end

endmodule

// File: rtl/bus_arb_top.sv
// Top level of the bus ownership arbiter.
// One handshake controller per master plus the central arbiter. The busy line
// is the wired-AND of every master's active-low busy drive.
// Assumes: NREQ >= 2. Host controls are synchronous to clk.
module bus_arb_top #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] want_i,
    input  logic [NREQ-1:0] done_i,
    output logic [NREQ-1:0] br_n_o,
    output logic [NREQ-1:0] bg_n_o,
    output logic            bb_n_o,
    output logic [NREQ-1:0] own_o
);

    logic [NREQ-1:0] busy_drv;

    for (genvar mi = 0; mi < NREQ; mi++) begin : g_mst
        bus_req_ctl u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .want_i     (want_i[mi]),
            .done_i     (done_i[mi]),
            .bg_n_i     (bg_n_o[mi]),
            .bb_n_i     (bb_n_o),
            .br_n_o     (br_n_o[mi]),
            .busy_drv_o (busy_drv[mi]),
            .own_o      (own_o[mi])
        );
    end

    // Combine every master's busy drive onto the shared active-low line.
    always_comb bb_n_o = ~|busy_drv;

    bus_grant_arb #(.NREQ(NREQ)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .br_n_i (br_n_o),
        .bb_n_i (bb_n_o),
        .bg_n_o (bg_n_o)
    );

endmodule

// File: rtl/bus_arb_checker.sv
// Protocol checker for bus_arb_top, attached by bind.
// Assumes: observes only the top-level ports.
module bus_arb_checker #(
    parameter int NREQ = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREQ-1:0] done_i,
    input logic [NREQ-1:0] br_n_o,
    input logic [NREQ-1:0] bg_n_o,
    input logic            bb_n_o,
    input logic [NREQ-1:0] own_o
);

    localparam logic [NREQ-1:0] ALL_HI = '1;

    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bg_n_o));

    p_one_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_o));

    p_grant_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_n_o && bg_n_o != ALL_HI) |=> (bg_n_o == ALL_HI));

    p_no_grant_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bb_n_o && bg_n_o == ALL_HI) |=> (bg_n_o == ALL_HI));

    for (genvar ci = 0; ci < NREQ; ci++) begin : g_chk
        p_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(own_o[ci]) |-> (br_n_o[ci] && $past(!bg_n_o[ci]) && $past(bb_n_o)));

        p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (own_o[ci] && done_i[ci]) |=> !own_o[ci]);

        p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (own_o[ci] && !done_i[ci]) |=> own_o[ci]);
    end

endmodule

bind bus_arb_top bus_arb_checker #(.NREQ(NREQ)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_i (done_i),
    .br_n_o (br_n_o),
    .bg_n_o (bg_n_o),
    .bb_n_o (bb_n_o),
    .own_o  (own_o)
);

// File: tb/tb_bus_arb_top.sv
// Self-checking bench: directed handshake cases plus seeded random traffic,
// compared each cycle against a cycle model written from the requirements.
module tb_bus_arb_top;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] want, done;
    logic [N-1:0] br_n, bg_n, own;
    logic         bb_n;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    // Model state: 0 idle, 1 waiting, 2 owner.
    int m_st [N];
    bit m_gv;
    int m_g, m_last;

    always #10 clk = ~clk;   // 50 MHz

    bus_arb_top #(.NREQ(N)) dut (
        .clk(clk), .rst_n(rst_n), .want_i(want), .done_i(done),
        .br_n_o(br_n), .bg_n_o(bg_n), .bb_n_o(bb_n), .own_o(own)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_br();
        for (int i = 0; i < N; i++) exp_br[i] = !(m_st[i] == 1);
    endfunction
    function automatic logic [N-1:0] exp_bg();
        for (int i = 0; i < N; i++) exp_bg[i] = !(m_gv && m_g == i);
    endfunction
    function automatic logic [N-1:0] exp_own();
        for (int i = 0; i < N; i++) exp_own[i] = (m_st[i] == 2);
    endfunction
    function automatic logic exp_bb();
        return !(|exp_own());
    endfunction
    function automatic int rr_pick();
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (m_last + off) % N;
            if (m_st[c] == 1) return c;
        end
        return -1;
    endfunction

    // Cycle model of the handshake.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_st[i] = 0;
            m_gv = 0; m_g = 0; m_last = N - 1;
        end else begin
            bit idle;
            int nst [N];
            int p;
            idle = exp_bb();
            for (int i = 0; i < N; i++) begin
                nst[i] = m_st[i];
                case (m_st[i])
                    0: if (want[i]) nst[i] = 1;
                    1: if (!want[i]) nst[i] = 0;
                       else if (m_gv && m_g == i && idle) nst[i] = 2;
                    default: if (done[i]) nst[i] = 0;
                endcase
            end
            p = rr_pick();
            if (!m_gv) begin
                if (idle && p >= 0) begin m_gv = 1; m_g = p; end
            end else if (!idle) begin
                m_gv = 0; m_last = m_g;
            end else if (m_st[m_g] != 1) begin
                m_gv = 0;
            end
            for (int i = 0; i < N; i++) m_st[i] = nst[i];
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(br_n == exp_br(),  "R2 request lines", br_n, exp_br());
            chk(bg_n == exp_bg(),  "R3 grant lines",   bg_n, exp_bg());
            chk(bb_n == exp_bb(),  "R4 busy line",     bb_n, exp_bb());
            chk(own  == exp_own(), "R9 owner flags",   own,  exp_own());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5713));
        rst_n = 1'b0; want = '0; done = '0;
        repeat (3) @(negedge clk);
        chk(br_n == 4'hF && bg_n == 4'hF && bb_n && own == 4'h0, "R1 reset state",
            {br_n, bg_n, own}, 12'hFF0);
        rst_n = 1'b1;

        // R2..R6: single master through the full handshake.
        want = 4'b0001;
        @(negedge clk); chk(br_n == 4'b1110, "R2 request one clock later", br_n, 4'b1110);
        @(negedge clk); chk(bg_n == 4'b1110, "R3 grant to master 0", bg_n, 4'b1110);
        @(negedge clk); chk(own == 4'b0001 && !bb_n && br_n == 4'hF,
                            "R4 claim drops request", {br_n, own}, 8'hF1);
        @(negedge clk); chk(bg_n == 4'hF, "R5 grant withdrawn after busy", bg_n, 4'hF);
        done = 4'b0001; want = 4'b0000;
        @(negedge clk); done = '0;
        chk(bb_n && own == 4'h0, "R6 release after done", own, 0);

        // R6: stray done pulses with no owner.
        done = 4'hF;
        @(negedge clk); done = '0;
        chk(bb_n && own == 4'h0 && br_n == 4'hF && bg_n == 4'hF,
            "R6 done ignored when not owner", {br_n, bg_n}, 8'hFF);

        // R8: master 2 gives up before claiming.
        want = 4'b0100;
        @(negedge clk); want = '0;
        @(negedge clk); chk(bg_n == 4'b1011 && br_n == 4'hF, "R8 request withdrawn",
                            {br_n, bg_n}, 8'hFB);
        @(negedge clk); chk(bg_n == 4'hF && own == 4'h0, "R8 grant lost, no ownership",
                            {bg_n, own}, 8'hF0);

        // R7: all masters requesting; last owner was 0, so order starts at 1.
        want = 4'hF;
        for (int k = 0; k < 8; k++) begin
            int w;
            w = 0;
            while (own == 4'h0 && w < 20) begin @(negedge clk); w++; end
            chk(own == 4'(1 << ((1 + k) % N)), "R7 circular winner order",
                own, 1 << ((1 + k) % N));
            done = own;
            @(negedge clk); done = '0;
        end
        want = '0;
        repeat (6) @(negedge clk);

        // R10: owner keeps the bus with want low, until done.
        want = 4'b1000;
        repeat (3) @(negedge clk);
        want = '0;
        repeat (4) @(negedge clk);
        chk(own == 4'b1000 && !bb_n, "R10 ownership held without want", own, 4'b1000);
        done = 4'b1000;
        @(negedge clk); done = '0;
        chk(own == 4'h0 && bb_n, "R10 released on done", own, 0);

        // Random traffic against the model.
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                if ($urandom % 6 == 0) want[i] = ~want[i];
                done[i] = own[i] ? ($urandom % 4 == 0) : ($urandom % 16 == 0);
            end
        end
        want = '0; done = '0;
        repeat (4) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule